// File: doc/BRIEF.md
# Three-State Write-Invalidate Line Coherence Controller

This block keeps one line of a write-back cache coherent with its peers on a shared snooping bus. The line is in one of three states: Invalid, Shared (clean, read-only) or Exclusive (dirty, writable). Two kinds of event change that state. The first is a processor access, which carries a hit flag from a tag compare outside this block. The second is a snooped bus request from another cache, which carries a match flag saying that the request names the block this line holds.

Any bus action the controller decides on (a read miss, a write miss or a write-back of the dirty block) is raised as a valid/ready request. `bus_req_valid` is the valid and `bus_grant` is the ready. While `bus_grant` is low, the request stays up and its command stays unchanged, and the controller waits in a pending state. A single command completes on the cycle in which valid and grant are both high. The processor side is valid/ready as well. A request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high, and `cpu_req_ready` stays low while any bus action is pending.

The block does not hold data, compare tags or arbitrate for the bus.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: A processor read miss on an Invalid or Shared line raises a read-miss command (code 1). The line becomes Shared on the grant cycle of that command. A read with the hit flag on an Invalid line counts as a miss.
- R2: A processor write on an Invalid line, or on a Shared line whether it hits or not, raises a write-miss command (code 2). The line becomes Exclusive on its grant.
- R3: A read hit on a Shared or Exclusive line, and a write hit on an Exclusive line, raise no bus command and leave the state unchanged.
- R4: A matching snooped write miss moves a Shared line to Invalid. This also happens while a processor miss is pending. A matching snooped read miss on a Shared line has no effect.
- R5: A matching snooped read miss on an Exclusive line raises a write-back command (code 3). The line becomes Shared on its grant.
- R6: A matching snooped write miss on an Exclusive line raises a write-back. The line becomes Invalid on its grant.
- R7: A processor miss (read or write) on an Exclusive line first raises a write-back. On that grant the line goes Invalid. The new miss command is raised next, and completes as in R1 or R2.
- R8: A raised bus request keeps `bus_req_valid` high and `bus_req_cmd` unchanged until `bus_grant` is seen high. While idle, `bus_req_cmd` is 0.
- R9: While `snp_valid` is high, `cpu_req_ready` is low. A processor request in the same cycle as a snoop is therefore not taken, and the snoop is acted on.
- R10: During and right after reset, the line is Invalid (state code 0, Shared 1, Exclusive 2), no bus request is raised, and `cpu_req_ready` is high. Reset clears a pending action.
- R11: A snoop with `snp_match` low leaves the line state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor access present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_hit | input | 1 | Tag compare hit for this access |
| cpu_req_ready | output | 1 | Access taken this cycle when valid is high |
| snp_valid | input | 1 | Snooped bus request present |
| snp_write | input | 1 | 1 = snooped write miss, 0 = snooped read miss |
| snp_match | input | 1 | Snooped address names the block held here |
| bus_req_valid | output | 1 | Bus command raised |
| bus_req_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_grant | input | 1 | Bus available; completes the raised command |
| line_state | output | 2 | 0 Invalid, 1 Shared, 2 Exclusive |

## Verification
A snoop and a processor access can arrive in the same cycle, and the snoop has to win. The bench provokes this by driving a matching snooped read miss together with a write hit on an Exclusive line. It then checks that `cpu_req_ready` is low in that cycle, that a write-back is raised rather than nothing, and that the line ends Shared instead of staying Exclusive. A second overlap has a snooped write miss landing on a Shared line while that line's own write miss waits for grant. The bench checks that the line drops to Invalid at once and that the held command still completes into Exclusive.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int LINE_W = 2;
  localparam int CMD_W  = 2;
  localparam int CTL_W  = 2;

  typedef enum logic [LINE_W-1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_e;

  typedef enum logic [CMD_W-1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WRBACK = 2'd3
  } bcmd_e;

  typedef enum logic [CTL_W-1:0] {
    CT_IDLE      = 2'd0,
    CT_WAIT_WB   = 2'd1,
    CT_WAIT_MISS = 2'd2
  } ctl_e;

  // Decision produced each cycle for the sequencer
  typedef struct packed {
    logic  start_wb;    // enter write-back wait
    logic  start_miss;  // a miss command follows (or starts now)
    bcmd_e miss_cmd;
    line_e after_wb;    // line state once write-back is granted
    line_e fin;         // line state once miss is granted
    logic  set_now;     // immediate state change without bus
    line_e now_val;
  } plan_t;
endpackage

// File: rtl/coh_plan.sv
module coh_plan
  import coh_pkg::*;
(
  input  line_e line_q,
  input  logic  idle,
  input  logic  snp_valid,
  input  logic  snp_write,
  input  logic  snp_match,
  input  logic  cpu_valid,
  input  logic  cpu_write,
  input  logic  cpu_hit,
  output logic  cpu_take,
  output logic  cpu_ready,
  output plan_t plan
);
  logic snoop_hit;
  logic cpu_miss;

  assign snoop_hit = snp_valid && snp_match;
  // snoop has priority: processor side is stalled whenever a snoop is present
  assign cpu_ready = idle && !snp_valid;
  assign cpu_take  = cpu_ready && cpu_valid;
  assign cpu_miss  = !cpu_hit || (line_q == LN_INV);

  always_comb begin
    plan          = '0;
    plan.miss_cmd = BC_NONE;
    plan.after_wb = LN_INV;
    plan.fin      = LN_INV;
    plan.now_val  = LN_INV;

    // another cache writes the block: drop the clean copy at once
    if (snoop_hit && snp_write && line_q == LN_SHR) begin
      plan.set_now = 1'b1;
      plan.now_val = LN_INV;
    end

    if (idle && snoop_hit && line_q == LN_EXC) begin
      plan.start_wb = 1'b1;
      plan.after_wb = snp_write ? LN_INV : LN_SHR;
    end else if (cpu_take) begin
      if (!cpu_write) begin
        if (cpu_miss) begin
          plan.start_miss = 1'b1;
          plan.miss_cmd   = BC_RDMISS;
          plan.fin        = LN_SHR;
          plan.start_wb   = (line_q == LN_EXC);
        end
      end else if (!(cpu_hit && line_q == LN_EXC)) begin
        plan.start_miss = 1'b1;
        plan.miss_cmd   = BC_WRMISS;
        plan.fin        = LN_EXC;
        plan.start_wb   = cpu_miss && (line_q == LN_EXC);
      end
    end
  end
endmodule

// File: rtl/coh_bus_seq.sv
module coh_bus_seq
  import coh_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  plan_t plan,
  input  logic  bus_grant,
  output line_e line_q,
  output logic  idle,
  output logic  bus_req_valid,
  output bcmd_e bus_req_cmd
);
  ctl_e  ctl_q;
  logic  miss_pend_q;
  bcmd_e miss_cmd_q;
  line_e after_wb_q;
  line_e fin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q       <= CT_IDLE;
      line_q      <= LN_INV;
      miss_pend_q <= 1'b0;
      miss_cmd_q  <= BC_NONE;
      after_wb_q  <= LN_INV;
      fin_q       <= LN_INV;
    end else begin
      if (plan.set_now) line_q <= plan.now_val;
      unique case (ctl_q)
        CT_IDLE: begin
          if (plan.start_wb || plan.start_miss) begin
            ctl_q       <= plan.start_wb ? CT_WAIT_WB : CT_WAIT_MISS;
            miss_pend_q <= plan.start_miss;
            miss_cmd_q  <= plan.miss_cmd;
            after_wb_q  <= plan.after_wb;
            fin_q       <= plan.fin;
          end
        end
        CT_WAIT_WB: begin
          if (bus_grant) begin
            line_q <= after_wb_q;
            ctl_q  <= miss_pend_q ? CT_WAIT_MISS : CT_IDLE;
          end
        end
        CT_WAIT_MISS: begin
          if (bus_grant) begin
            line_q      <= fin_q;
            ctl_q       <= CT_IDLE;
            miss_pend_q <= 1'b0;
          end
        end
        default: ctl_q <= CT_IDLE;
      endcase
    end
  end

  assign idle          = (ctl_q == CT_IDLE);
  assign bus_req_valid = !idle;
  assign bus_req_cmd   = (ctl_q == CT_WAIT_WB)   ? BC_WRBACK :
                         (ctl_q == CT_WAIT_MISS) ? miss_cmd_q : BC_NONE;

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_grant) |=> (bus_req_valid && $stable(bus_req_cmd)));

  assert_wb_only_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_cmd == BC_WRBACK) |-> (line_q == LN_EXC));

  assert_rdmiss_shared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_cmd == BC_RDMISS && bus_grant) |=> (line_q == LN_SHR));
endmodule

// File: rtl/coh_snoop_ctrl.sv
module coh_snoop_ctrl
  import coh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req_valid,
  input  logic             cpu_req_write,
  input  logic             cpu_req_hit,
  output logic             cpu_req_ready,
  input  logic             snp_valid,
  input  logic             snp_write,
  input  logic             snp_match,
  output logic             bus_req_valid,
  output logic [CMD_W-1:0] bus_req_cmd,
  input  logic             bus_grant,
  output logic [LINE_W-1:0] line_state
);
  line_e line_q;
  logic  idle;
  logic  cpu_take;
  plan_t plan;
  bcmd_e cmd_e;

  coh_plan u_plan (
    .line_q    (line_q),
    .idle      (idle),
    .snp_valid (snp_valid),
    .snp_write (snp_write),
    .snp_match (snp_match),
    .cpu_valid (cpu_req_valid),
    .cpu_write (cpu_req_write),
    .cpu_hit   (cpu_req_hit),
    .cpu_take  (cpu_take),
    .cpu_ready (cpu_req_ready),
    .plan      (plan)
  );

  coh_bus_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .plan          (plan),
    .bus_grant     (bus_grant),
    .line_q        (line_q),
    .idle          (idle),
    .bus_req_valid (bus_req_valid),
    .bus_req_cmd   (cmd_e)
  );

  assign bus_req_cmd = cmd_e;
  assign line_state  = line_q;

  assert_snoop_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_req_ready);

  assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && cpu_req_hit && line_state == LN_EXC)
      |=> (!bus_req_valid && line_state == LN_EXC));

  assert_shared_inval_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_match && snp_write && line_state == LN_SHR && !bus_grant)
      |=> (line_state == LN_INV));

  assert_wrmiss_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_req_cmd == BC_WRMISS && bus_grant) |=> (line_state == LN_EXC));
endmodule

// File: tb/coh_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module coh_snoop_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req_valid, cpu_req_write, cpu_req_hit, cpu_req_ready;
  logic snp_valid, snp_write, snp_match;
  logic bus_req_valid, bus_grant;
  logic [1:0] bus_req_cmd, line_state;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  coh_snoop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_hit(cpu_req_hit), .cpu_req_ready(cpu_req_ready),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_match(snp_match),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
    .bus_grant(bus_grant), .line_state(line_state)
  );

  // inputs for one cycle, ready during that cycle, outputs after the edge
  typedef struct packed {
    logic sv, sk, sm, cv, cw, ch, g;
    logic rdy;
    logic [1:0] st;
    logic bv;
    logic [1:0] cmd;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{0,0,0,1,0,0,0, 1,2'd0,1,2'd1, 4'd1},  // R1 read miss from Invalid
    '{0,0,0,0,0,0,1, 0,2'd1,0,2'd0, 4'd1},  // R1 grant -> Shared
    '{0,0,0,1,0,1,0, 1,2'd1,0,2'd0, 4'd3},  // R3 read hit Shared
    '{1,0,1,0,0,0,0, 0,2'd1,0,2'd0, 4'd4},  // R4 snoop read on Shared ignored
    '{0,0,0,1,1,1,0, 1,2'd1,1,2'd2, 4'd2},  // R2 write hit on Shared
    '{0,0,0,0,0,0,0, 0,2'd1,1,2'd2, 4'd8},  // R8 held without grant
    '{0,0,0,0,0,0,1, 0,2'd2,0,2'd0, 4'd2},  // R2 grant -> Exclusive
    '{0,0,0,1,1,1,0, 1,2'd2,0,2'd0, 4'd3},  // R3 write hit Exclusive
    '{0,0,0,1,0,1,0, 1,2'd2,0,2'd0, 4'd3},  // R3 read hit Exclusive
    '{1,0,1,0,0,0,0, 0,2'd2,1,2'd3, 4'd5},  // R5 snoop read on Exclusive
    '{0,0,0,0,0,0,1, 0,2'd1,0,2'd0, 4'd5},  // R5 grant -> Shared
    '{1,1,1,0,0,0,0, 0,2'd0,0,2'd0, 4'd4},  // R4 snoop write on Shared
    '{0,0,0,1,1,0,0, 1,2'd0,1,2'd2, 4'd2},  // R2 write miss Invalid
    '{0,0,0,0,0,0,1, 0,2'd2,0,2'd0, 4'd2},  // R2
    '{0,0,0,1,0,0,0, 1,2'd2,1,2'd3, 4'd7},  // R7 read miss on dirty line
    '{0,0,0,0,0,0,1, 0,2'd0,1,2'd1, 4'd7},  // R7 write-back done, read miss
    '{0,0,0,0,0,0,1, 0,2'd1,0,2'd0, 4'd7},  // R7 -> Shared
    '{0,0,0,1,1,0,0, 1,2'd1,1,2'd2, 4'd2},  // R2 write miss Shared
    '{0,0,0,0,0,0,1, 0,2'd2,0,2'd0, 4'd2},  // R2
    '{1,1,1,0,0,0,0, 0,2'd2,1,2'd3, 4'd6},  // R6 snoop write on Exclusive
    '{0,0,0,0,0,0,1, 0,2'd0,0,2'd0, 4'd6},  // R6 grant -> Invalid
    '{0,0,0,1,0,1,0, 1,2'd0,1,2'd1, 4'd1},  // R1 hit flag on Invalid = miss
    '{0,0,0,0,0,0,1, 0,2'd1,0,2'd0, 4'd1},  // R1
    '{1,1,1,0,0,0,0, 0,2'd0,0,2'd0, 4'd4},  // R4
    '{0,0,0,1,1,0,0, 1,2'd0,1,2'd2, 4'd2},  // R2
    '{0,0,0,0,0,0,1, 0,2'd2,0,2'd0, 4'd2},  // R2
    '{0,0,0,1,1,0,0, 1,2'd2,1,2'd3, 4'd7},  // R7 write miss on dirty line
    '{0,0,0,0,0,0,1, 0,2'd0,1,2'd2, 4'd7},  // R7
    '{0,0,0,0,0,0,1, 0,2'd2,0,2'd0, 4'd7},  // R7
    '{1,0,1,1,1,1,0, 0,2'd2,1,2'd3, 4'd9},  // R9 snoop and cpu together
    '{0,0,0,0,0,0,1, 0,2'd1,0,2'd0, 4'd9},  // R9 snoop result wins
    '{1,1,0,0,0,0,0, 0,2'd1,0,2'd0, 4'd11}, // R11 unmatched snoop write
    '{0,0,0,1,1,0,0, 1,2'd1,1,2'd2, 4'd2},  // R2 write miss Shared
    '{1,1,1,0,0,0,0, 0,2'd0,1,2'd2, 4'd4},  // R4 invalidate while pending
    '{0,0,0,0,0,0,1, 0,2'd2,0,2'd0, 4'd2}   // R2 pending miss completes
  };

  task automatic check(input string what, input int rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cpu_req_valid = 0; cpu_req_write = 0; cpu_req_hit = 0;
    snp_valid = 0; snp_write = 0; snp_match = 0; bus_grant = 0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("state in reset", 10, line_state, 0);
    check("bus valid in reset", 10, bus_req_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("ready after reset", 10, cpu_req_ready, 1);
    check("cmd idle", 8, bus_req_cmd, 0);

    for (int i = 0; i < NV; i++) begin
      {snp_valid, snp_write, snp_match, cpu_req_valid, cpu_req_write,
       cpu_req_hit, bus_grant} = {VEC[i].sv, VEC[i].sk, VEC[i].sm, VEC[i].cv,
                                  VEC[i].cw, VEC[i].ch, VEC[i].g};
      #1;
      check($sformatf("vec %0d ready", i), VEC[i].rq, cpu_req_ready, VEC[i].rdy);
      @(negedge clk);
      idle_inputs();
      check($sformatf("vec %0d state", i), VEC[i].rq, line_state, VEC[i].st);
      check($sformatf("vec %0d bus valid", i), VEC[i].rq, bus_req_valid, VEC[i].bv);
      check($sformatf("vec %0d bus cmd", i), VEC[i].rq, bus_req_cmd, VEC[i].cmd);
    end

    // R11 unmatched snoop read on Exclusive line: no write-back
    cpu_req_valid = 1; cpu_req_write = 1; cpu_req_hit = 1;  // line is Exclusive now
    @(negedge clk); idle_inputs();
    snp_valid = 1; snp_match = 0;
    @(negedge clk); idle_inputs();
    check("unmatched snoop bus", 11, bus_req_valid, 0);
    check("unmatched snoop state", 11, line_state, 2);

    // R10 reset clears a pending action
    cpu_req_valid = 1;  // read miss on dirty line -> write-back pending
    @(negedge clk); idle_inputs();
    check("pending before reset", 10, bus_req_valid, 1);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("reset clears pending", 10, bus_req_valid, 0);
    check("reset clears state", 10, line_state, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule